// File: doc/BRIEF.md
# Receive Byte Match Filter

This block sits beside the receive path of a bus master that reads bytes from a two-wire serial bus. For every received byte it gets three things: the byte, a flag from the command path that marks the byte as thrown away by command, and a marker that a START or repeated START came before the byte. It compares kept bytes against configured reference values and raises a sticky match flag when a comparison succeeds.

There are two comparison styles. In pair mode a byte matches when it equals either of two reference bytes. In masked mode one reference acts as a bit mask, and the byte matches when it equals the other reference on every bit that the mask selects. The comparison can cover every kept byte, or only the first one or the first two kept bytes after the latest START. Discarded bytes are not counted when this window is measured.

A gating option makes the block hold back received data until a match appears. While gating is on and no match has been seen, kept bytes are not written to the receive FIFO. The matching byte and the bytes after it are written. Software takes the block out of gating by clearing the gate bit first and the match flag second.

Top module: `rx_match_filter`

## Requirements
- R1: With `cfg_cmp_mode` = 1 (pair), an eligible byte sets `match_flag` exactly when it equals `cfg_ref_a` or `cfg_ref_b`.
- R2: With `cfg_cmp_mode` = 2 (masked), an eligible byte sets `match_flag` exactly when `(byte ^ cfg_ref_a) & cfg_ref_b` is zero, so `cfg_ref_b` is the mask.
- R3: With `cfg_cmp_mode` = 0 or 3, no byte ever sets `match_flag`.
- R4: A byte presented with `byte_discard` = 1 never sets `match_flag`, is never written to the FIFO, and does not advance the window count.
- R5: `cfg_window` = 0 or 3 makes every kept byte eligible. A value of 1 makes only the first kept byte after a START eligible, and 2 makes only the first two eligible. `start_mark` restarts the count, and a byte in the same cycle as `start_mark` counts as the first one. The count saturates at 2.
- R6: `match_flag` is sticky and is cleared only by a `flag_clr` pulse. A match in the same cycle as `flag_clr` leaves the flag set.
- R7: With `cfg_gate` = 0, every kept byte produces `fifo_wr` = 1 with `fifo_data` equal to the byte in the following cycle. With no byte valid, `fifo_wr` is 0.
- R8: With `cfg_gate` = 1 and `match_flag` clear, a kept byte that does not match is dropped, and the matching byte itself is written.
- R9: With `cfg_gate` = 1 and `match_flag` set, kept bytes are written. If the flag is cleared while the gate is still set, dropping resumes. If the gate is cleared first and the flag after it, all later bytes are written.
- R10: After reset, `match_flag` and `fifo_wr` are 0 and the window count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_vld | input | 1 | A received byte is present this cycle |
| byte_data | input | DATA_W | Received byte |
| byte_discard | input | 1 | Byte is thrown away by command |
| start_mark | input | 1 | A START or repeated START came before this byte |
| cfg_cmp_mode | input | 2 | 0 off, 1 pair, 2 masked, 3 off |
| cfg_window | input | 2 | 0 all, 1 first kept, 2 first two kept, 3 all |
| cfg_ref_a | input | DATA_W | First reference byte |
| cfg_ref_b | input | DATA_W | Second reference byte, or the mask in masked mode |
| cfg_gate | input | 1 | Hold data back until a match |
| flag_clr | input | 1 | Write-one-to-clear pulse for the match flag |
| match_flag | output | 1 | Sticky match indication |
| fifo_wr | output | 1 | Write strobe to the receive FIFO |
| fifo_data | output | DATA_W | Byte to write to the FIFO |

## Verification
Every byte value is sent once in pair mode and once in masked mode, with the flag cleared on each byte. This shows that exactly the two references match in pair mode and that only the masked bits decide in masked mode. A sweep then covers all sixteen pairs of comparison mode and window setting, both with and without gating, using one stream that mixes matching bytes, non-matching bytes, discards, START markers and clears. This separates window counting that includes discards from counting that skips them, and separates forwarding of the matching byte from dropping it. Directed sequences cover a match and a clear arriving together, a START in the same cycle as a byte, and both orders of leaving gating.

// File: rtl/rxm_pkg.sv
package rxm_pkg;
  typedef enum logic [1:0] {
    CMP_OFF  = 2'd0,
    CMP_PAIR = 2'd1,
    CMP_MASK = 2'd2,
    CMP_RSVD = 2'd3
  } cmp_mode_e;

  typedef enum logic [1:0] {
    WIN_ALL    = 2'd0,
    WIN_FIRST1 = 2'd1,
    WIN_FIRST2 = 2'd2,
    WIN_RSVD   = 2'd3
  } win_mode_e;

  localparam int WIN_CNT_W = 2;
  localparam int WIN_MAX   = 2;
endpackage

// File: rtl/rxm_window.sv
module rxm_window
  import rxm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       kept,
  input  logic       start_mark,
  input  logic [1:0] win_sel,
  output logic       eligible
);
  logic [WIN_CNT_W-1:0] cnt_q;
  logic [WIN_CNT_W-1:0] cnt_eff;
  logic [WIN_CNT_W-1:0] cnt_nxt;
  win_mode_e            mode;

  assign mode    = win_mode_e'(win_sel);
  // R5: a START restarts the count, and the byte in that cycle is the first
  assign cnt_eff = start_mark ? '0 : cnt_q;

  always_comb begin
    unique case (mode)
      WIN_FIRST1: eligible = kept && (cnt_eff < WIN_CNT_W'(1));
      WIN_FIRST2: eligible = kept && (cnt_eff < WIN_CNT_W'(2));
      default:    eligible = kept;
    endcase
  end

  // R4: only kept bytes advance the count; saturates at WIN_MAX
  always_comb begin
    cnt_nxt = cnt_eff;
    if (kept && (cnt_eff != WIN_CNT_W'(WIN_MAX)))
      cnt_nxt = cnt_eff + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;   // R10
    else     cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/rxm_compare.sv
module rxm_compare
  import rxm_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int NUM_REF = 2
) (
  input  logic [DATA_W-1:0]         data,
  input  logic [NUM_REF*DATA_W-1:0] refs,
  input  logic [1:0]                mode_sel,
  output logic                      equal
);
  logic [NUM_REF-1:0] ref_eq;
  logic [DATA_W-1:0]  ref_a;
  logic [DATA_W-1:0]  ref_m;
  logic               mask_eq;
  cmp_mode_e          mode;

  assign mode = cmp_mode_e'(mode_sel);

  genvar g;
  generate
    for (g = 0; g < NUM_REF; g++) begin : g_ref
      assign ref_eq[g] = (data == refs[g*DATA_W +: DATA_W]);
    end
  endgenerate

  assign ref_a   = refs[0 +: DATA_W];
  assign ref_m   = refs[DATA_W +: DATA_W];
  // R2: the second reference selects which bits take part
  assign mask_eq = ~|((data ^ ref_a) & ref_m);

  always_comb begin
    unique case (mode)
      CMP_PAIR: equal = |ref_eq;   // R1
      CMP_MASK: equal = mask_eq;   // R2
      default:  equal = 1'b0;      // R3
    endcase
  end
endmodule

// File: rtl/rxm_gate.sv
module rxm_gate #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              kept,
  input  logic              hit,
  input  logic              gate_en,
  input  logic              flag_clr,
  input  logic [DATA_W-1:0] data_in,
  output logic              match_flag,
  output logic              fifo_wr,
  output logic [DATA_W-1:0] fifo_data
);
  logic flag_q;
  logic fwd;

  // R8/R9: pass when not gated, after a match, or on the matching byte
  assign fwd = kept && (!gate_en || flag_q || hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q    <= 1'b0;   // R10
      fifo_wr   <= 1'b0;
      fifo_data <= '0;
    end else begin
      flag_q  <= hit | (flag_q & ~flag_clr);   // R6: set wins over clear
      fifo_wr <= fwd;                           // R7
      if (fwd) fifo_data <= data_in;
    end
  end

  assign match_flag = flag_q;
endmodule

// File: rtl/rx_match_filter.sv
module rx_match_filter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_vld,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              byte_discard,
  input  logic              start_mark,
  input  logic [1:0]        cfg_cmp_mode,
  input  logic [1:0]        cfg_window,
  input  logic [DATA_W-1:0] cfg_ref_a,
  input  logic [DATA_W-1:0] cfg_ref_b,
  input  logic              cfg_gate,
  input  logic              flag_clr,
  output logic              match_flag,
  output logic              fifo_wr,
  output logic [DATA_W-1:0] fifo_data
);
  localparam int NUM_REF = 2;

  logic kept;
  logic eligible;
  logic equal;
  logic hit;

  // R4: a discarded byte is never kept
  assign kept = byte_vld && !byte_discard;

  rxm_window u_window (
    .clk        (clk),
    .rst        (rst),
    .kept       (kept),
    .start_mark (start_mark),
    .win_sel    (cfg_window),
    .eligible   (eligible)
  );

  rxm_compare #(.DATA_W(DATA_W), .NUM_REF(NUM_REF)) u_compare (
    .data     (byte_data),
    .refs     ({cfg_ref_b, cfg_ref_a}),
    .mode_sel (cfg_cmp_mode),
    .equal    (equal)
  );

  assign hit = eligible && equal;

  rxm_gate #(.DATA_W(DATA_W)) u_gate (
    .clk        (clk),
    .rst        (rst),
    .kept       (kept),
    .hit        (hit),
    .gate_en    (cfg_gate),
    .flag_clr   (flag_clr),
    .data_in    (byte_data),
    .match_flag (match_flag),
    .fifo_wr    (fifo_wr),
    .fifo_data  (fifo_data)
  );
endmodule

// File: rtl/rxm_checker.sv
module rxm_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              byte_vld,
  input logic [DATA_W-1:0] byte_data,
  input logic              byte_discard,
  input logic [1:0]        cfg_cmp_mode,
  input logic              cfg_gate,
  input logic              flag_clr,
  input logic              match_flag,
  input logic              fifo_wr,
  input logic [DATA_W-1:0] fifo_data
);
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!match_flag && !fifo_wr));   // R10

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (match_flag && !flag_clr) |=> match_flag);   // R6

  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (match_flag && flag_clr && !byte_vld) |=> !match_flag);   // R6

  AST_DISCARD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (byte_vld && byte_discard) |=> !fifo_wr);   // R4

  AST_DISCARD_NO_SET: assert property (@(posedge clk) disable iff (rst)
    (!match_flag && !(byte_vld && !byte_discard)) |=> !match_flag);   // R4

  AST_OFF_NO_SET: assert property (@(posedge clk) disable iff (rst)
    (!match_flag && (cfg_cmp_mode == 2'd0 || cfg_cmp_mode == 2'd3)) |=> !match_flag);   // R3

  AST_UNGATED_PASS: assert property (@(posedge clk) disable iff (rst)
    (byte_vld && !byte_discard && !cfg_gate) |=> (fifo_wr && fifo_data == $past(byte_data)));   // R7

  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    !byte_vld |=> !fifo_wr);   // R7

  AST_GATED_DROP: assert property (@(posedge clk) disable iff (rst)
    (byte_vld && cfg_gate && !match_flag) |=> (fifo_wr == match_flag));   // R8

  AST_GATED_OPEN: assert property (@(posedge clk) disable iff (rst)
    (byte_vld && !byte_discard && match_flag) |=> fifo_wr);   // R9
endmodule

bind rx_match_filter rxm_checker #(.DATA_W(DATA_W)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .byte_vld     (byte_vld),
  .byte_data    (byte_data),
  .byte_discard (byte_discard),
  .cfg_cmp_mode (cfg_cmp_mode),
  .cfg_gate     (cfg_gate),
  .flag_clr     (flag_clr),
  .match_flag   (match_flag),
  .fifo_wr      (fifo_wr),
  .fifo_data    (fifo_data)
);

// File: tb/rx_match_filter_tb.sv
module rx_match_filter_tb_top;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          byte_vld = 1'b0;
  logic [DW-1:0] byte_data = '0;
  logic          byte_discard = 1'b0;
  logic          start_mark = 1'b0;
  logic [1:0]    cfg_cmp_mode = 2'd0;
  logic [1:0]    cfg_window = 2'd0;
  logic [DW-1:0] cfg_ref_a = 8'h5A;
  logic [DW-1:0] cfg_ref_b = 8'hC3;
  logic          cfg_gate = 1'b0;
  logic          flag_clr = 1'b0;
  logic          match_flag;
  logic          fifo_wr;
  logic [DW-1:0] fifo_data;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic       m_flag = 1'b0;
  logic [1:0] m_cnt = 2'd0;

  always #4 clk = ~clk;   // 125 MHz

  rx_match_filter #(.DATA_W(DW)) dut_i (
    .clk(clk), .rst(rst), .byte_vld(byte_vld), .byte_data(byte_data),
    .byte_discard(byte_discard), .start_mark(start_mark),
    .cfg_cmp_mode(cfg_cmp_mode), .cfg_window(cfg_window),
    .cfg_ref_a(cfg_ref_a), .cfg_ref_b(cfg_ref_b), .cfg_gate(cfg_gate),
    .flag_clr(flag_clr), .match_flag(match_flag), .fifo_wr(fifo_wr),
    .fifo_data(fifo_data)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h (mode %0d win %0d gate %0d)",
               tag, what, act, exp, cfg_cmp_mode, cfg_window, cfg_gate);
    end
  endtask

  // One cycle: drive at a falling edge, predict, check at the next falling edge.
  task automatic step(input logic v, input logic d, input logic [7:0] dat,
                      input logic st, input logic cl, input string tag);
    logic [1:0] eff;
    logic kept, elig, cmp, hit, ewr;
    byte_vld = v; byte_discard = d; byte_data = dat; start_mark = st; flag_clr = cl;
    eff  = st ? 2'd0 : m_cnt;
    kept = v && !d;
    case (cfg_window)
      2'd1:    elig = kept && (eff < 2'd1);
      2'd2:    elig = kept && (eff < 2'd2);
      default: elig = kept;
    endcase
    case (cfg_cmp_mode)
      2'd1:    cmp = (dat == cfg_ref_a) || (dat == cfg_ref_b);
      2'd2:    cmp = ((dat ^ cfg_ref_a) & cfg_ref_b) == 8'h00;
      default: cmp = 1'b0;
    endcase
    hit = elig && cmp;
    ewr = kept && (!cfg_gate || m_flag || hit);
    m_flag = hit || (m_flag && !cl);
    if (kept && eff != 2'd2) m_cnt = eff + 2'd1;
    else                     m_cnt = eff;
    @(negedge clk);
    check(tag, "fifo_wr", int'(fifo_wr), int'(ewr));
    if (ewr) check(tag, "fifo_data", int'(fifo_data), int'(dat));
    check(tag, "match_flag", int'(match_flag), int'(m_flag));
    byte_vld = 1'b0; byte_discard = 1'b0; start_mark = 1'b0; flag_clr = 1'b0;
  endtask

  task automatic cfg(input int m, input int w, input logic g);
    cfg_cmp_mode = 2'(m); cfg_window = 2'(w); cfg_gate = g;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_flag = 1'b0; m_cnt = 2'd0;
    @(negedge clk);
    check("R10", "match_flag", int'(match_flag), 0);
    check("R10", "fifo_wr", int'(fifo_wr), 0);

    // R1 exhaustive pair compare; clear on every byte so the flag shows this byte
    cfg(1, 0, 1'b0);
    for (int b = 0; b < 256; b++) step(1'b1, 1'b0, 8'(b), 1'b0, 1'b1, "R1");
    // R2 exhaustive masked compare: ref_a=5A, mask C3 -> bits 7,6,1,0 decide
    cfg(2, 0, 1'b0);
    for (int b = 0; b < 256; b++) step(1'b1, 1'b0, 8'(b), 1'b0, 1'b1, "R2");
    step(1'b0, 1'b0, 8'h00, 1'b0, 1'b1, "R6");

    // R4: discarded match ignored and does not use up the first-byte window
    cfg(1, 1, 1'b0);
    step(1'b1, 1'b1, 8'h5A, 1'b1, 1'b0, "R4");
    step(1'b1, 1'b0, 8'h5A, 1'b0, 1'b0, "R4");
    step(1'b0, 1'b0, 8'h00, 1'b0, 1'b1, "R6");

    // R5: third kept byte is outside a two-byte window; START in same cycle counts
    cfg(1, 2, 1'b0);
    step(1'b1, 1'b0, 8'h11, 1'b1, 1'b0, "R5");
    step(1'b1, 1'b0, 8'h22, 1'b0, 1'b0, "R5");
    step(1'b1, 1'b0, 8'hC3, 1'b0, 1'b0, "R5");
    step(1'b1, 1'b0, 8'h5A, 1'b0, 1'b0, "R5");
    step(1'b1, 1'b0, 8'hC3, 1'b1, 1'b0, "R5");

    // R6: clear alone drops the flag; match with clear keeps it
    step(1'b0, 1'b0, 8'h00, 1'b0, 1'b1, "R6");
    step(1'b1, 1'b0, 8'h5A, 1'b1, 1'b1, "R6");
    step(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, "R6");
    step(1'b0, 1'b0, 8'h00, 1'b0, 1'b1, "R6");

    // R8/R9: gating order
    cfg(1, 0, 1'b1);
    step(1'b1, 1'b0, 8'h33, 1'b1, 1'b0, "R8");
    step(1'b1, 1'b0, 8'h5A, 1'b0, 1'b0, "R8");
    step(1'b1, 1'b0, 8'h34, 1'b0, 1'b0, "R9");
    step(1'b0, 1'b0, 8'h00, 1'b0, 1'b1, "R9");
    step(1'b1, 1'b0, 8'h35, 1'b0, 1'b0, "R9");
    step(1'b1, 1'b0, 8'hC3, 1'b0, 1'b0, "R9");
    cfg_gate = 1'b0;
    step(1'b0, 1'b0, 8'h00, 1'b0, 1'b1, "R9");
    step(1'b1, 1'b0, 8'h36, 1'b0, 1'b0, "R9");

    // Sweep every mode/window/gate combination with a mixed stream
    for (int m = 0; m < 4; m++)
      for (int w = 0; w < 4; w++)
        for (int g = 0; g < 2; g++) begin
          cfg(m, w, 1'(g));
          step(1'b0, 1'b0, 8'h00, 1'b1, 1'b1, "R6");
          for (int i = 0; i < 24; i++) begin
            logic [7:0] dv;
            dv = (i % 3 == 0) ? cfg_ref_a : (i % 3 == 1) ? 8'(8'h17 * i) : cfg_ref_b;
            step(1'b1, (i % 5 == 3), dv, (i % 7 == 0), (i % 9 == 8),
                 (m == 0 || m == 3) ? "R3" : (g == 1) ? "R8" : "R7");
          end
        end

    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule